// File: doc/BRIEF.md
# Event-Logging Serial Receive Channel

This block is one receive channel of a multi-channel serial port. It watches an asynchronous RX line, taking samples on an 8x oversampling tick. It does not collect bytes in a FIFO. It turns the line activity into a stream of 16-bit tagged events and writes them into a shared ring memory through a plain write port. The block sees three kinds of event: a received character, a break (the line held low beyond a full character), and an idle gap longer than a selectable threshold. Break and idle events carry their duration in bit times. Durations too long for ten bits use a coarse scaled form.

Each entry carries a fixed channel tag, so software that drains the ring can tell which channel wrote it. The channel keeps its own wrapping count of the entries it has written. It raises an interrupt when that count reaches a compare value, and also whenever it logs an idle gap. The interrupt stays set until a clear pulse arrives. Arbitration between channels that share one ring is handled outside this block.

Top module: `rx_event_logger`

## Requirements
- R1: Each entry is written at address `ring_addr`, shown as `mem_addr` during the write cycle. The pointer then advances by one and wraps from RING_DEPTH-1 (default 2048 entries) to 0. The pointer is 0 after reset.
- R2: Entry bits 15:13 hold CHAN_ID and bits 12:11 hold the kind: 00 character, 01 break, 10 idle. The value 11 is never written.
- R3: A falling edge is confirmed as a start bit by a low sample half a bit later. Then `char_bits` data bits (5 to 9) are taken LSB first, one per bit time. They are stored left-justified in bits 10:0: the last data bit goes in bit 10 and the first in bit 11-`char_bits`. Bits below those are don't-care.
- R4: A duration field below 1024 bit times is stored as bit 10 = 0 with the length in bits 9:0. A longer duration sets bit 10 and stores the length shifted right by 6 in bits 9:0. The duration counter saturates.
- R5: A frame with all-zero data and a low stop bit starts a break. The break length is counted in bit times from the stop-bit sample. The break entry is written when the line returns high, whatever its length. An all-zero character with a high stop bit is logged as a character.
- R6: High time is counted in bit times from the last stop-bit sample (or the end of a break). An idle entry is written at the next start edge, ahead of that character, only if this count exceeds the threshold chosen by `idle_sel` (00 = 1, 01 = 8, 10 = 16, 11 = 32).
- R7: While `en` is low, the receiver returns to its idle state and writes nothing. The pointer and the count keep their values.
- R8: `entry_cnt` is 0 after reset and rises by exactly one for each entry written, wrapping modulo 2^CNT_W. It has no write path.
- R9: `irq` is 0 after reset. It is set in the cycle of a write whose new count equals `cmp_val`, or of an idle write. It stays set until `irq_clr` is high; a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Channel enable |
| rx | input | 1 | Serial receive line |
| tick | input | 1 | One-cycle pulse at 8x the bit rate |
| char_bits | input | 4 | Data bits per character, 5 to 9 |
| idle_sel | input | 2 | Idle threshold select |
| cmp_val | input | CNT_W | Entry count compare value |
| irq_clr | input | 1 | Interrupt clear pulse |
| mem_we | output | 1 | Ring memory write strobe |
| mem_addr | output | log2(RING_DEPTH) | Ring memory write address |
| mem_wdata | output | 16 | Entry written to the ring |
| ring_addr | output | log2(RING_DEPTH) | Next ring write position |
| entry_cnt | output | CNT_W | Wrapping count of entries written |
| irq | output | 1 | Receive interrupt |

## Verification
The assertions assume three things about the inputs. `char_bits` stays within 5 to 9 whenever the channel is enabled. `char_bits` and `idle_sel` change only while the line is idle, never in the middle of a frame. `tick` is a single-cycle pulse. The stimulus changes these settings only during idle gaps between frames. It drives `rx` in whole bit times of sixteen clocks against a tick on every second clock, and checks durations within one bit time to allow for the sampling phase. It keeps gaps well away from each idle threshold, so that whether an idle entry appears never depends on the tick phase.

// File: rtl/rxlog_pkg.sv
package rxlog_pkg;

   localparam int LEN_W  = 16;
   localparam int BODY_W = 11;

   typedef enum logic [1:0] {
      EV_CHAR  = 2'b00,
      EV_BREAK = 2'b01,
      EV_IDLE  = 2'b10
   } ev_kind_e;

   // Compact duration field: exact below 1024, else flagged and divided by 64.
   function automatic logic [BODY_W-1:0] enc_len(input logic [LEN_W-1:0] n);
      if (n < LEN_W'(1024)) return {1'b0, n[9:0]};
      else                  return {1'b1, n[LEN_W-1:6]};
   endfunction

   function automatic logic [LEN_W-1:0] idle_limit(input logic [1:0] sel);
      case (sel)
         2'b00:   return LEN_W'(1);
         2'b01:   return LEN_W'(8);
         2'b10:   return LEN_W'(16);
         default: return LEN_W'(32);
      endcase
   endfunction

endpackage

// File: rtl/rxlog_sampler.sv
module rxlog_sampler
   import rxlog_pkg::*;
#(
   parameter int OVS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              rx,
   input  logic [3:0]        char_bits,
   input  logic [1:0]        idle_sel,
   output logic              ev_valid,
   output ev_kind_e          ev_kind,
   output logic [BODY_W-1:0] ev_body
);
   localparam int PW = $clog2(OVS);
   localparam logic [PW-1:0] MID  = PW'(OVS / 2 - 1);
   localparam logic [PW-1:0] LAST = PW'(OVS - 1);

   typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_BRK} st_e;

   st_e               st;
   logic [PW-1:0]     ph;
   logic [PW-1:0]     sub;
   logic [LEN_W-1:0]  run;
   logic [3:0]        nb;
   logic [BODY_W-1:0] sh;
   logic              rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; ph <= '0; sub <= '0; run <= '0; nb <= '0; sh <= '0;
         rx_q <= 1'b0; ev_valid <= 1'b0; ev_kind <= EV_CHAR; ev_body <= '0;
      end else begin
         ev_valid <= 1'b0;
         if (!en) begin
            st <= S_IDLE; ph <= '0; sub <= '0; run <= '0; nb <= '0; sh <= '0;
            rx_q <= 1'b0;
         end else if (tick) begin
            rx_q <= rx;
            case (st)
               S_IDLE: begin
                  if (rx_q && !rx) begin
                     if (run > idle_limit(idle_sel)) begin
                        ev_valid <= 1'b1;
                        ev_kind  <= EV_IDLE;
                        ev_body  <= enc_len(run);
                     end
                     st <= S_START; ph <= '0; sh <= '0; nb <= '0;
                  end else if (rx) begin
                     sub <= sub + 1'b1;
                     if (sub == LAST && run != '1) run <= run + 1'b1;
                  end
               end
               S_START: begin
                  ph <= ph + 1'b1;
                  if (ph == MID) begin
                     if (!rx) begin
                        st <= S_DATA; ph <= '0;
                     end else begin
                        st <= S_IDLE; run <= '0; sub <= '0;
                     end
                  end
               end
               S_DATA: begin
                  ph <= ph + 1'b1;
                  if (ph == LAST) begin
                     sh <= {rx, sh[BODY_W-1:1]};
                     nb <= nb + 1'b1;
                     if (nb == char_bits - 4'd1) st <= S_STOP;
                  end
               end
               S_STOP: begin
                  ph <= ph + 1'b1;
                  if (ph == LAST) begin
                     run <= '0; sub <= '0;
                     if (!rx && sh == '0) begin
                        st <= S_BRK;
                     end else begin
                        ev_valid <= 1'b1;
                        ev_kind  <= EV_CHAR;
                        ev_body  <= sh;
                        st       <= S_IDLE;
                     end
                  end
               end
               S_BRK: begin
                  if (rx) begin
                     ev_valid <= 1'b1;
                     ev_kind  <= EV_BREAK;
                     ev_body  <= enc_len(run);
                     st <= S_IDLE; run <= '0; sub <= '0;
                  end else begin
                     sub <= sub + 1'b1;
                     if (sub == LAST && run != '1) run <= run + 1'b1;
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   // R2: the unused kind code never leaves the receiver
   a_r2_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |-> ev_kind != 2'b11);

   // R4: a scaled duration always stands for at least 1024 bit times
   a_r4_long_scale: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && ev_kind != EV_CHAR && ev_body[10] |-> ev_body[9:0] >= 10'd16);

   // R5: a break is entered only from the stop-bit sample
   a_r5_brk_entry: assert property (@(posedge clk) disable iff (!rst_n)
      st == S_BRK && $past(st) != S_BRK |-> $past(st) == S_STOP);

   // R6: an exact idle length always exceeds the selected threshold
   a_r6_idle_over: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && ev_kind == EV_IDLE && !ev_body[10]
      |-> {5'b0, ev_body} > idle_limit($past(idle_sel)));

   // R7: no event follows a disabled cycle
   a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !ev_valid);

endmodule

// File: rtl/rxlog_ring.sv
module rxlog_ring
   import rxlog_pkg::*;
#(
   parameter int DEPTH   = 2048,
   parameter int CNT_W   = 8,
   parameter int CHAN_ID = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ev_valid,
   input  ev_kind_e                 ev_kind,
   input  logic [BODY_W-1:0]        ev_body,
   input  logic [CNT_W-1:0]         cmp_val,
   input  logic                     irq_clr,
   output logic                     mem_we,
   output logic [$clog2(DEPTH)-1:0] mem_addr,
   output logic [15:0]              mem_wdata,
   output logic [$clog2(DEPTH)-1:0] ring_addr,
   output logic [CNT_W-1:0]         entry_cnt,
   output logic                     irq
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [2:0] CH = 3'(CHAN_ID);

   logic [CNT_W-1:0] cnt_nx;
   assign cnt_nx = entry_cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
         ring_addr <= '0; entry_cnt <= '0; irq <= 1'b0;
      end else begin
         mem_we <= ev_valid;
         if (ev_valid) begin
            mem_addr  <= ring_addr;
            mem_wdata <= {CH, ev_kind, ev_body};
            ring_addr <= ring_addr + 1'b1;
            entry_cnt <= cnt_nx;
         end
         if (ev_valid && (cnt_nx == cmp_val || ev_kind == EV_IDLE)) irq <= 1'b1;
         else if (irq_clr)                                           irq <= 1'b0;
      end
   end

   // R1: every write lands at the pointer held before it
   a_r1_addr_seq: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_addr == $past(ring_addr));

   // R2: the stored kind field is never the reserved code
   a_r2_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_wdata[12:11] != 2'b11);

   // R8: the count steps by one per write and holds otherwise
   a_r8_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> entry_cnt == $past(entry_cnt) + 1'b1);
   a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we |-> $stable(entry_cnt));

   // R9: the interrupt rises only with a write and holds until cleared
   a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> mem_we);
   a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !irq_clr |=> irq);

   logic [AW-1:0] unused_aw;
   assign unused_aw = '0;

endmodule

// File: rtl/rx_event_logger.sv
module rx_event_logger
   import rxlog_pkg::*;
#(
   parameter int CHAN_ID    = 0,
   parameter int RING_DEPTH = 2048,
   parameter int CNT_W      = 8,
   parameter int OVS        = 8,
   localparam int AW        = $clog2(RING_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             rx,
   input  logic             tick,
   input  logic [3:0]       char_bits,
   input  logic [1:0]       idle_sel,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             irq_clr,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [15:0]      mem_wdata,
   output logic [AW-1:0]    ring_addr,
   output logic [CNT_W-1:0] entry_cnt,
   output logic             irq
);
   if (RING_DEPTH < 2 || (RING_DEPTH & (RING_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("RING_DEPTH must be a power of two");
   end
   if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("OVS must be a power of two of at least 4");
   end
   if (CHAN_ID < 0 || CHAN_ID > 7) begin : g_bad_chan
      $error("CHAN_ID must fit in three bits");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must be 1 to 16");
   end

   logic              ev_valid;
   ev_kind_e          ev_kind;
   logic [BODY_W-1:0] ev_body;

   rxlog_sampler #(.OVS(OVS)) u_sampler (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .rx(rx),
      .char_bits(char_bits), .idle_sel(idle_sel),
      .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_body(ev_body)
   );

   rxlog_ring #(.DEPTH(RING_DEPTH), .CNT_W(CNT_W), .CHAN_ID(CHAN_ID)) u_ring (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
      .ev_body(ev_body), .cmp_val(cmp_val), .irq_clr(irq_clr),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .ring_addr(ring_addr), .entry_cnt(entry_cnt), .irq(irq)
   );

   // R3: the character size stays within the supported range while enabled
   a_r3_bits_range: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> char_bits >= 4'd5 && char_bits <= 4'd9);

endmodule

// File: tb/rx_event_logger_test.sv
module rx_event_logger_test;
   localparam int DEPTH = 64;
   localparam int CH    = 5;

   logic clk = 1'b0;
   logic rst_n, en, rx, irq_clr;
   logic tick = 1'b0;
   logic [3:0] char_bits;
   logic [1:0] idle_sel;
   logic [7:0] cmp_val;
   logic       mem_we, irq;
   logic [5:0] mem_addr, ring_addr;
   logic [15:0] mem_wdata;
   logic [7:0] entry_cnt;

   always #4 clk = ~clk;
   always @(posedge clk) tick <= ~tick;

   rx_event_logger #(.CHAN_ID(CH), .RING_DEPTH(DEPTH), .CNT_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .en(en), .rx(rx), .tick(tick),
      .char_bits(char_bits), .idle_sel(idle_sel), .cmp_val(cmp_val),
      .irq_clr(irq_clr), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .ring_addr(ring_addr), .entry_cnt(entry_cnt),
      .irq(irq)
   );

   // {data bits, data, expected left-justified field}
   localparam logic [23:0] VEC [0:7] = '{
      {4'd8, 9'h0A5, 11'h528}, {4'd8, 9'h000, 11'h000},
      {4'd8, 9'h0FF, 11'h7F8}, {4'd7, 9'h055, 11'h550},
      {4'd5, 9'h013, 11'h4C0}, {4'd9, 9'h1A3, 11'h68C},
      {4'd6, 9'h02D, 11'h5A0}, {4'd8, 9'h001, 11'h008}
   };

   int checks = 0, fails = 0, capt_n = 0, addr_err = 0;
   bit done = 1'b0;
   logic [15:0] entries [0:511];

   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         entries[capt_n % 512] = mem_wdata;
         if (mem_addr != 6'(capt_n % DEPTH)) addr_err++;
         capt_n++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic bits(input int n);
      repeat (n * 16) @(negedge clk);
   endtask

   task automatic send_char(input logic [8:0] d, input int n, input int gap);
      rx = 1'b0; bits(1);
      for (int i = 0; i < n; i++) begin rx = d[i]; bits(1); end
      rx = 1'b1; bits(1 + gap);
   endtask

   task automatic pulse_clr();
      irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int base;
      logic [15:0] e;
      logic [5:0] a0;
      rx = 1'b1; en = 1'b1; irq_clr = 1'b0; char_bits = 4'd8;
      idle_sel = 2'b11; cmp_val = 8'd200; rst_n = 1'b0;
      repeat (5) @(negedge clk);
      chk(mem_we == 1'b0 && ring_addr == 6'd0, "R1", "reset pointer", int'(ring_addr), 0);
      chk(entry_cnt == 8'd0, "R8", "reset count", int'(entry_cnt), 0);
      chk(irq == 1'b0, "R9", "reset irq", int'(irq), 0);
      rst_n = 1'b1;
      bits(2);

      // character table
      for (int i = 0; i < 8; i++) begin
         int n;
         logic [10:0] f, m;
         n = int'(VEC[i][23:20]);
         f = VEC[i][10:0];
         m = 11'(((1 << n) - 1) << (11 - n));
         base = capt_n;
         char_bits = VEC[i][23:20];
         send_char(VEC[i][19:11], n, 3);
         chk(capt_n == base + 1, "R3", "one entry per character", capt_n - base, 1);
         e = entries[base % 512];
         chk(e[15:13] == 3'(CH) && e[12:11] == 2'b00, "R2", "character header",
             int'(e[15:11]), CH * 4);
         chk((e[10:0] & m) == f, "R3", "character field", int'(e[10:0] & m), int'(f));
         chk(ring_addr == 6'(capt_n % DEPTH), "R1", "pointer advance",
             int'(ring_addr), capt_n % DEPTH);
      end

      // idle threshold of 8 bit times
      char_bits = 4'd8; idle_sel = 2'b01; base = capt_n;
      send_char(9'h03C, 8, 4);
      send_char(9'h0C3, 8, 14);
      chk(capt_n == base + 2, "R6", "short gap writes no idle entry", capt_n - base, 2);
      chk(irq == 1'b0, "R9", "no irq before idle", int'(irq), 0);
      send_char(9'h066, 8, 3);
      e = entries[(base + 2) % 512];
      chk(e[12:11] == 2'b10 && !e[10] && e[9:0] >= 10'd13 && e[9:0] <= 10'd16,
          "R6", "idle entry length near 14", int'(e[10:0]), 14);
      e = entries[(base + 3) % 512];
      chk(e[12:11] == 2'b00 && e[10:3] == 8'h66, "R6", "character after idle entry",
          int'(e[10:0]), 'h330);
      chk(irq == 1'b1, "R9", "idle entry raises irq", int'(irq), 1);
      pulse_clr();
      chk(irq == 1'b0, "R9", "clear drops irq", int'(irq), 0);

      // idle threshold of 1 bit time
      idle_sel = 2'b00; base = capt_n;
      send_char(9'h011, 8, 3);
      e = entries[base % 512];
      chk(capt_n == base + 2 && e[12:11] == 2'b10 && e[9:0] >= 10'd2 && e[9:0] <= 10'd5,
          "R6", "idle entry at threshold 1", int'(e), 3);
      pulse_clr();
      idle_sel = 2'b11;
      bits(2);

      // short break
      base = capt_n;
      rx = 1'b0; bits(25);
      chk(capt_n == base, "R5", "no entry while line low", capt_n - base, 0);
      bits(5); rx = 1'b1; bits(4);
      e = entries[base % 512];
      chk(capt_n == base + 1 && e[12:11] == 2'b01, "R5", "break entry kind",
          int'(e[12:11]), 1);
      chk(!e[10] && e[9:0] >= 10'd19 && e[9:0] <= 10'd22, "R4", "short break length",
          int'(e[10:0]), 20);

      // long break with scaled length
      base = capt_n;
      rx = 1'b0; bits(1110); rx = 1'b1; bits(4);
      e = entries[base % 512];
      chk(e == {3'(CH), 2'b01, 11'h411}, "R4", "scaled break length", int'(e),
          int'({3'(CH), 2'b01, 11'h411}));
      bits(3);

      // count compare interrupt
      cmp_val = 8'((capt_n + 2) % 256);
      send_char(9'h011, 8, 3);
      chk(irq == 1'b0, "R9", "no match yet", int'(irq), 0);
      send_char(9'h022, 8, 3);
      chk(irq == 1'b1, "R9", "count match raises irq", int'(irq), 1);
      bits(10);
      chk(irq == 1'b1, "R9", "irq holds", int'(irq), 1);
      pulse_clr();
      chk(irq == 1'b0, "R9", "clear after match", int'(irq), 0);
      chk(entry_cnt == 8'(capt_n % 256), "R8", "count tracks entries",
          int'(entry_cnt), capt_n % 256);

      // disabled channel
      en = 1'b0; a0 = ring_addr; base = capt_n;
      send_char(9'h05A, 8, 3);
      chk(capt_n == base && ring_addr == a0, "R7", "no write while disabled",
          capt_n - base, 0);
      en = 1'b1; bits(2);
      send_char(9'h05A, 8, 3);
      chk(capt_n == base + 1, "R7", "write resumes after enable", capt_n - base, 1);

      // ring and count wrap
      char_bits = 4'd5;
      for (int i = 0; i < 300; i++) send_char(9'(i & 31), 5, 1);
      chk(capt_n > 256, "R8", "enough entries to wrap", capt_n, 257);
      chk(entry_cnt == 8'(capt_n % 256), "R8", "count wraps", int'(entry_cnt),
          capt_n % 256);
      chk(ring_addr == 6'(capt_n % DEPTH), "R1", "pointer wraps", int'(ring_addr),
          capt_n % DEPTH);
      chk(addr_err == 0, "R1", "write address sequence", addr_err, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule